// File: doc/BRIEF.md
# Duty-Based Interleaved Gate Sequencer

This block drives the switches of an interleaved boost stage built from `N_CELLS` parallel cells, working from one duty command. A carrier count supplied from outside defines the switching period. The period is split into `N_CELLS` equal sub-periods. Inside each sub-period the block forms a fast control pulse. While the pulse is high, one more cell conducts than while it is low. The duty word alone sets the operating region and the width of that pulse. No voltage measurement takes part. Any duty from zero up to one count below full scale is reached without a clamp.

Every change in the number of conducting cells moves exactly one gate. The cell that moves is picked from the per-cell current samples, which keeps the cell currents balanced. When a cell must be added, the block turns on the idle cell that carries the lowest current. When a cell must be removed, it turns off the conducting cell that carries the highest current. On a tie, the lower cell index wins.

The duty and the region are captured once per carrier period, at the wrap, so a pulse is never cut short in the middle of a period. After reset all gates stay off until the first carrier wrap has been seen.

Top module: `interleave_gate_seq`

## Requirements
- R1: With P = 2^CNT_W and S = P/N_CELLS, the register that captures the duty loads on the clock edge at which `carrier` equals P-1. From the following cycle, `region` shows N_CELLS-1-floor(duty/S). Before the first capture after reset, `region` shows N_CELLS-1.
- R2: Take k = floor(duty/S) and f = duty mod S, using the captured duty. Once the captured duty is the same as in the previous period, the gate output that follows a clock edge with carrier value c has k+1 cells on when (c mod S) < f, and k cells on otherwise. This is N-region cells on while the pulse is high and N-region-1 cells on while it is low.
- R3: When the captured duty is an exact multiple of S and equals the previous period's duty, the number of gates on stays at k for the whole period.
- R4: A change on `duty` in the middle of a carrier period affects neither `region` nor the gates until the next wrap at carrier P-1.
- R5: When the target count is above the present count, exactly one idle cell turns on. It is the idle cell with the smallest `cell_cur` value, and on a tie the lowest index. Cell i's sample occupies bits [i*CUR_W +: CUR_W].
- R6: When the target count is below the present count, exactly one conducting cell turns off. It is the conducting cell with the largest `cell_cur` value, and on a tie the lowest index.
- R7: From one clock to the next the number of gates on changes by at most one. A larger jump in the target is reached one cell per clock.
- R8: A synchronous `rst` turns all gates off and sets `region` to N_CELLS-1. All gates stay off until the first capture edge at carrier P-1 after reset.
- R9: Over a carrier period whose captured duty equals the previous one, the sum over all cells of gate-on cycles is N_CELLS*duty. This holds at every duty, including 0, 1 and P-1.
- R10: For two cells, a duty of at least one half selects region 0, with two cells on during the pulse and one otherwise. A duty below one half selects region 1, with one cell on during the pulse and none otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the carrier advances one count per clock |
| rst | input | 1 | Synchronous reset, active high |
| duty | input | CNT_W | Duty command as a fraction of 2^CNT_W |
| carrier | input | CNT_W | Carrier count, 0 to 2^CNT_W-1, wrapping |
| cell_cur | input | N_CELLS*CUR_W | Unsigned current sample per cell, cell 0 in the low bits |
| gate | output | N_CELLS | Switch gate drive, one bit per cell |
| region | output | $clog2(N_CELLS) | Operating region captured at the last wrap |

## Verification
The hardest behaviour to reach from the ports is the current-based choice at the moment the conducting count steps. On each such step there is exactly one decision, and it depends on the samples present on that cycle. Ties and multi-cell slews after a duty jump arise only rarely under natural stimulus. The stimulus therefore redraws every cell's current on every clock. For long stretches it limits the samples to the values 0 and 1, so that ties happen at nearly every step. It also jumps the duty across several region boundaries at once, for two-cell and four-cell instances side by side. A behavioural model judges every gate vector and period sum against these conditions.

// File: rtl/interleave_gate_seq.sv
module interleave_gate_seq #(
  parameter int N_CELLS = 2,
  parameter int CNT_W   = 8,
  parameter int CUR_W   = 12,
  localparam int RW     = $clog2(N_CELLS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         duty,
  input  logic [CNT_W-1:0]         carrier,
  input  logic [N_CELLS*CUR_W-1:0] cell_cur,
  output logic [N_CELLS-1:0]       gate,
  output logic [RW-1:0]            region
);
  localparam int SUB_W = CNT_W - RW;
  localparam logic [RW-1:0] TOP = RW'(N_CELLS - 1);

  logic [RW-1:0]      k_q;
  logic [SUB_W-1:0]   frac_q;
  logic               armed_q;
  logic [N_CELLS-1:0] gate_q, gate_nxt;
  logic [RW:0]        cnt, tgt;
  logic               pulse;

  logic               lo_found, hi_found;
  logic [RW-1:0]      lo_idx, hi_idx;
  logic [CUR_W-1:0]   lo_val, hi_val, cv;

  assign pulse  = carrier[SUB_W-1:0] < frac_q;
  assign tgt    = armed_q ? ({1'b0, k_q} + {{RW{1'b0}}, pulse}) : '0;
  assign gate   = gate_q;
  assign region = TOP - k_q;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N_CELLS; i++) cnt = cnt + (RW+1)'(gate_q[i]);
  end

  always_comb begin
    lo_found = 1'b0; lo_idx = '0; lo_val = '0;
    hi_found = 1'b0; hi_idx = '0; hi_val = '0;
    cv = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      cv = cell_cur[i*CUR_W +: CUR_W];
      if (!gate_q[i] && (!lo_found || cv < lo_val)) begin
        lo_found = 1'b1; lo_idx = RW'(i); lo_val = cv;
      end
      if (gate_q[i] && (!hi_found || cv > hi_val)) begin
        hi_found = 1'b1; hi_idx = RW'(i); hi_val = cv;
      end
    end
  end

  always_comb begin
    gate_nxt = gate_q;
    if (tgt > cnt && lo_found)      gate_nxt[lo_idx] = 1'b1;
    else if (tgt < cnt && hi_found) gate_nxt[hi_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q     <= '0;
      frac_q  <= '0;
      armed_q <= 1'b0;
      gate_q  <= '0;
    end else begin
      gate_q <= gate_nxt;
      if (carrier == '1) begin
        k_q     <= duty[CNT_W-1:SUB_W];
        frac_q  <= duty[SUB_W-1:0];
        armed_q <= 1'b1;
      end
    end
  end

  logic                     past_ok;
  logic [N_CELLS-1:0]       gate_d;
  logic [N_CELLS*CUR_W-1:0] cur_d;
  logic [RW+1:0]            cnt_w, cnt_d;

  assign cnt_w = {1'b0, cnt};

  always_ff @(posedge clk) begin
    past_ok <= !rst;
    gate_d  <= gate_q;
    cur_d   <= cell_cur;
    cnt_d   <= cnt_w;
  end

  assert_gates_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> gate_q == '0);

  assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (cnt_w <= cnt_d + 1'b1) && (cnt_d <= cnt_w + 1'b1));

  always @(posedge clk) begin
    if (!rst && past_ok) begin
      for (int i = 0; i < N_CELLS; i++) begin
        for (int j = 0; j < N_CELLS; j++) begin
          if (j != i && gate_q[i] && !gate_d[i] && !gate_d[j])
            assert_pick_on_R5: assert (cur_d[i*CUR_W +: CUR_W] < cur_d[j*CUR_W +: CUR_W] ||
              (cur_d[i*CUR_W +: CUR_W] == cur_d[j*CUR_W +: CUR_W] && i < j));
          if (j != i && !gate_q[i] && gate_d[i] && gate_d[j])
            assert_pick_off_R6: assert (cur_d[i*CUR_W +: CUR_W] > cur_d[j*CUR_W +: CUR_W] ||
              (cur_d[i*CUR_W +: CUR_W] == cur_d[j*CUR_W +: CUR_W] && i < j));
        end
      end
    end
  end
endmodule

// File: tb/interleave_gate_seq_tb.sv
module interleave_gate_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int CUR_W = 6;
  localparam int P = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] carrier = 8'hFF;
  logic [CNT_W-1:0] duty2 = '0, duty4 = '0;
  logic [2*CUR_W-1:0] cur2 = '0;
  logic [4*CUR_W-1:0] cur4 = '0;
  logic [1:0] gate2;
  logic [3:0] gate4;
  logic       region2;
  logic [1:0] region4;

  interleave_gate_seq #(.N_CELLS(2), .CNT_W(CNT_W), .CUR_W(CUR_W)) u_dut (
    .clk(clk), .rst(rst), .duty(duty2), .carrier(carrier),
    .cell_cur(cur2), .gate(gate2), .region(region2));

  interleave_gate_seq #(.N_CELLS(4), .CNT_W(CNT_W), .CUR_W(CUR_W)) u_dut4 (
    .clk(clk), .rst(rst), .duty(duty4), .carrier(carrier),
    .cell_cur(cur4), .gate(gate4), .region(region4));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0, started = 0;
  int want_d2 = 0, want_d4 = 0, cur_mode = 0;
  bit want_rst = 1;
  int c_prev = 0;
  bit r_prev = 1, midchg = 0;
  int loads = 0;
  int mk[2], mfrac[2];
  bit marmed[2];
  logic [3:0] mgate[2];
  int ld_cur[2], ld_prev[2], ld_prev2[2], psum[2];
  bit sum_ok[2];

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ones(logic [3:0] g);
    int c = 0;
    for (int i = 0; i < 4; i++) c += int'(g[i]);
    return c;
  endfunction

  task automatic model_edge(int m, int c, int d, logic [23:0] cur, bit r);
    int n, s, tgt, cnt, bi, best, v;
    n = m ? 4 : 2;
    s = P / n;
    if (r) begin
      mk[m] = 0; mfrac[m] = 0; marmed[m] = 0; mgate[m] = '0;
      return;
    end
    tgt = marmed[m] ? mk[m] + (((c % s) < mfrac[m]) ? 1 : 0) : 0;
    cnt = ones(mgate[m]);
    bi = -1; best = 0;
    if (tgt > cnt) begin
      for (int i = 0; i < n; i++) begin
        v = int'(cur[i*CUR_W +: CUR_W]);
        if (!mgate[m][i] && (bi < 0 || v < best)) begin bi = i; best = v; end
      end
      if (bi >= 0) mgate[m][bi] = 1'b1;
    end else if (tgt < cnt) begin
      for (int i = 0; i < n; i++) begin
        v = int'(cur[i*CUR_W +: CUR_W]);
        if (mgate[m][i] && (bi < 0 || v > best)) begin bi = i; best = v; end
      end
      if (bi >= 0) mgate[m][bi] = 1'b0;
    end
    if (c == P-1) begin
      mk[m] = d / s; mfrac[m] = d % s; marmed[m] = 1;
    end
  endtask

  task automatic observe();
    int n, s, k, f, cnt, er;
    logic [3:0] g;
    int rg;
    for (int m = 0; m < 2; m++) begin
      n = m ? 4 : 2;
      s = P / n;
      g = m ? gate4 : {2'b00, gate2};
      rg = m ? int'(region4) : int'(region2);
      cnt = ones(g);
      chk(g == mgate[m], "R5 R6 R7 gate vector vs model", int'(g), int'(mgate[m]));
      er = (loads >= 1) ? n - 1 - ld_cur[m] / s : n - 1;
      chk(rg == er, "R1 region", rg, er);
      if (loads == 0) begin
        chk(g == 4'b0, "R8 gates off before first wrap", int'(g), 0);
        chk(rg == n - 1, "R8 region after reset", rg, n - 1);
      end
      k = ld_cur[m] / s;
      f = ld_cur[m] % s;
      if (loads >= 2 && ld_cur[m] == ld_prev[m] && c_prev != P-1) begin
        if (f != 0)
          chk(cnt == k + (((c_prev % s) < f) ? 1 : 0), "R2 count per pulse state",
              cnt, k + (((c_prev % s) < f) ? 1 : 0));
        else
          chk(cnt == k, "R3 constant count at exact multiple", cnt, k);
      end
      if (m == 0 && loads >= 1 && c_prev == P-2)
        chk(rg == ((ld_cur[0] >= P/2) ? 0 : 1), "R10 two-cell region",
            rg, (ld_cur[0] >= P/2) ? 0 : 1);
      if (midchg && c_prev == 200)
        chk(rg == n - 1 - 200 / s, "R4 mid-period duty change ignored", rg, n - 1 - 200 / s);
      if (r_prev) sum_ok[m] = 0;
      else if (c_prev == 0) begin psum[m] = cnt; sum_ok[m] = 1; end
      else if (sum_ok[m]) psum[m] += cnt;
      if (!r_prev && c_prev == P-1 && sum_ok[m]) begin
        if (loads >= 3 && ld_prev[m] == ld_prev2[m])
          chk(psum[m] == n * ld_prev[m], "R9 period on-time sum", psum[m], n * ld_prev[m]);
        sum_ok[m] = 0;
      end
    end
    if (midchg && c_prev == 200) midchg = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    if (started) observe();
    started = 1;
    rst = want_rst;
    carrier = carrier + 8'd1;
    duty2 = CNT_W'(want_d2);
    duty4 = CNT_W'(want_d4);
    for (int i = 0; i < 2; i++)
      cur2[i*CUR_W +: CUR_W] = CUR_W'(cur_mode ? $urandom % 2 : $urandom % 64);
    for (int i = 0; i < 4; i++)
      cur4[i*CUR_W +: CUR_W] = CUR_W'(cur_mode ? $urandom % 2 : $urandom % 64);
    model_edge(0, int'(carrier), int'(duty2), {12'b0, cur2}, rst);
    model_edge(1, int'(carrier), int'(duty4), cur4, rst);
    if (rst) loads = 0;
    else if (carrier == 8'hFF) begin
      for (int m = 0; m < 2; m++) begin
        ld_prev2[m] = ld_prev[m];
        ld_prev[m] = ld_cur[m];
        ld_cur[m] = m ? int'(duty4) : int'(duty2);
      end
      loads++;
    end
    c_prev = int'(carrier);
    r_prev = rst;
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) cyc();
  endtask

  int list2[8] = '{0, 1, 127, 128, 129, 255, 64, 192};
  int list4[12] = '{0, 1, 63, 64, 65, 127, 128, 191, 192, 193, 255, 32};
  int seed_dummy;

  initial begin
    seed_dummy = $urandom(32'h5eed);
    for (int m = 0; m < 2; m++) begin
      mk[m] = 0; mfrac[m] = 0; marmed[m] = 0; mgate[m] = '0;
      ld_cur[m] = 0; ld_prev[m] = 0; ld_prev2[m] = 0; psum[m] = 0; sum_ok[m] = 0;
    end
    want_rst = 1;
    run(5);
    want_rst = 0;
    run(300);
    for (int i = 0; i < 12; i++) begin
      want_d2 = list2[i % 8];
      want_d4 = list4[i];
      cur_mode = i % 2;
      run(3 * P);
    end
    for (int i = 0; i < 20; i++) begin
      want_d2 = int'($urandom % P);
      want_d4 = int'($urandom % P);
      cur_mode = (i % 3 == 0) ? 1 : 0;
      run(3 * P);
    end
    want_d2 = 200; want_d4 = 200;
    run(2 * P);
    while (c_prev != 100) cyc();
    want_d2 = 30; want_d4 = 30;
    midchg = 1;
    run(3 * P);
    run(77);
    want_rst = 1;
    run(3);
    want_rst = 0;
    want_d2 = 100; want_d4 = 100;
    run(4 * P);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule